// File: doc/BRIEF.md
# Compare-Flag and Conditional Branch Unit

This block holds the program counter and a single condition flag for a simple in-order core. Each cycle in which an operation is presented, it either compares two 32-bit operands and stores the outcome in the flag, or decides whether control flow changes and computes the next program counter. Conditional branches of both polarities read the flag. Unconditional jumps redirect without reading it. Jump-and-link forms also request a write of the return address into a link register.

The flag holds its value: only compare operations change it, so a compare can be placed many instructions ahead of the branch that uses it. All outputs are registered and show the result of an accepted operation one clock after it is presented. The `taken` output pulses for that one cycle when the program counter is redirected.

Top module: `cmpbr_unit`

## Requirements
- R1: After reset, `flag_o` is 0, `pc_o` equals the parameter `START_PC` (default 0x1000), and `taken_o` and `link_we_o` are 0.
- R2: Compare codes set `flag_o` to the comparison of `op_a` against `op_b`: 1 equal, 2 not-equal, 3 signed greater, 4 signed greater-or-equal, 5 signed less, 6 signed less-or-equal, 7 unsigned greater, 8 unsigned greater-or-equal, 9 unsigned less, 10 unsigned less-or-equal.
- R3: Any accepted operation whose code is not a compare (1 to 10) leaves `flag_o` unchanged.
- R4: Code 11 (branch if flag clear) is taken when the flag is 0. Code 12 (branch if flag set) is taken when the flag is 1. A taken branch loads `pc_o` with `tgt`.
- R5: A not-taken branch, code 0 (no-op) and any code from 17 to 31 advance `pc_o` by 4 and leave `taken_o` at 0.
- R6: Code 13 jumps to `tgt` and code 14 jumps to `op_a`. Neither requests a link write.
- R7: Code 15 jumps to `tgt` and code 16 jumps to `op_a`. Both raise `link_we_o` with `link_idx_o` = `lnk_dst` and `link_val_o` = the program counter of the operation plus 8.
- R8: A link write aimed at register index 0 is dropped, and `link_we_o` stays 0.
- R9: Every redirect raises `taken_o` for exactly the cycle in which `pc_o` shows the new target. Outputs change one clock after the operation is accepted.
- R10: While `op_valid` is 0, `pc_o` and `flag_o` hold their values and `taken_o` and `link_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation code (see R2 to R7) |
| op_a | input | 32 | First compare operand, or register jump target |
| op_b | input | 32 | Second compare operand |
| tgt | input | 32 | Immediate branch or jump target |
| lnk_dst | input | 5 | Link register index for jump-and-link |
| flag_o | output | 1 | Condition flag |
| pc_o | output | 32 | Current program counter |
| taken_o | output | 1 | Redirect happened on the last accepted operation |
| link_we_o | output | 1 | Link register write request |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Return address to write |

## Verification
The assertions check on every cycle that the flag holds across accepted operations other than compares, that idle cycles freeze state and keep the pulses low, and that branches with a known flag resolve to the target or to PC + 4. They also check that a link write is never raised for index 0 and carries the right return address. The exact result of each of the ten compare forms on sign-boundary operands, the order in which a flag set by one operation feeds a later branch, and recovery from a reset in the middle of a run can only be shown by the bench's scenarios.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 5;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,
        OP_EQ   = 5'd1,
        OP_NE   = 5'd2,
        OP_GTS  = 5'd3,
        OP_GES  = 5'd4,
        OP_LTS  = 5'd5,
        OP_LES  = 5'd6,
        OP_GTU  = 5'd7,
        OP_GEU  = 5'd8,
        OP_LTU  = 5'd9,
        OP_LEU  = 5'd10,
        OP_BFC  = 5'd11,
        OP_BFS  = 5'd12,
        OP_JMP  = 5'd13,
        OP_JREG = 5'd14,
        OP_JAL  = 5'd15,
        OP_JALR = 5'd16
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] pc;
        logic              flag;
        logic              taken;
        logic              link_we;
        logic [IDX_W-1:0]  link_idx;
        logic [DATA_W-1:0] link_val;
    } state_t;

    function automatic logic is_compare(input logic [4:0] code);
        return (code >= 5'd1) && (code <= 5'd10);
    endfunction
endpackage

// File: rtl/cmpbr_compare.sv
module cmpbr_compare
    import cmpbr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         hit
);
    logic eq_w, lts_w, ltu_w;

    assign eq_w  = (a == b);
    assign lts_w = ($signed(a) < $signed(b));
    assign ltu_w = (a < b);

    always_comb begin
        unique case (op)
            OP_EQ:   hit = eq_w;
            OP_NE:   hit = !eq_w;
            OP_GTS:  hit = !lts_w && !eq_w;
            OP_GES:  hit = !lts_w;
            OP_LTS:  hit = lts_w;
            OP_LES:  hit = lts_w || eq_w;
            OP_GTU:  hit = !ltu_w && !eq_w;
            OP_GEU:  hit = !ltu_w;
            OP_LTU:  hit = ltu_w;
            OP_LEU:  hit = ltu_w || eq_w;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmpbr_redirect.sv
module cmpbr_redirect
    import cmpbr_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IDX_W
) (
    input  op_e           op,
    input  logic          flag,
    input  logic [W-1:0]  reg_tgt,
    input  logic [W-1:0]  imm_tgt,
    input  logic [IW-1:0] lnk_dst,
    output logic          redirect,
    output logic [W-1:0]  dest,
    output logic          link_req
);
    logic use_reg, want_link;

    always_comb begin
        redirect  = 1'b0;
        use_reg   = 1'b0;
        want_link = 1'b0;
        unique case (op)
            OP_BFC:  redirect = !flag;
            OP_BFS:  redirect = flag;
            OP_JMP:  redirect = 1'b1;
            OP_JREG: begin redirect = 1'b1; use_reg = 1'b1; end
            OP_JAL:  begin redirect = 1'b1; want_link = 1'b1; end
            OP_JALR: begin redirect = 1'b1; use_reg = 1'b1; want_link = 1'b1; end
            default: redirect = 1'b0;
        endcase
        dest     = use_reg ? reg_tgt : imm_tgt;
        link_req = want_link && (lnk_dst != '0);
    end
endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
    import cmpbr_pkg::*;
#(
    parameter logic [31:0] START_PC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] tgt,
    input  logic [IDX_W-1:0]  lnk_dst,
    output logic              flag_o,
    output logic [DATA_W-1:0] pc_o,
    output logic              taken_o,
    output logic              link_we_o,
    output logic [IDX_W-1:0]  link_idx_o,
    output logic [DATA_W-1:0] link_val_o
);
    localparam logic [DATA_W-1:0] SEQ_STEP  = DATA_W'(4);
    localparam logic [DATA_W-1:0] LINK_STEP = DATA_W'(8);

    op_e               op;
    logic              cmp_hit;
    logic              redir;
    logic [DATA_W-1:0] redir_dest;
    logic              link_req;
    state_t            st_d, st_q;

    assign op = op_e'(op_code);

    cmpbr_compare #(.W(DATA_W)) u_cmp (
        .op  (op),
        .a   (op_a),
        .b   (op_b),
        .hit (cmp_hit)
    );

    cmpbr_redirect #(.W(DATA_W), .IW(IDX_W)) u_redir (
        .op       (op),
        .flag     (st_q.flag),
        .reg_tgt  (op_a),
        .imm_tgt  (tgt),
        .lnk_dst  (lnk_dst),
        .redirect (redir),
        .dest     (redir_dest),
        .link_req (link_req)
    );

    always_comb begin
        st_d         = st_q;
        st_d.taken   = 1'b0;
        st_d.link_we = 1'b0;
        if (op_valid) begin
            if (is_compare(op_code)) begin
                st_d.flag = cmp_hit;
            end
            st_d.pc    = redir ? redir_dest : st_q.pc + SEQ_STEP;
            st_d.taken = redir;
            if (link_req) begin
                st_d.link_we  = 1'b1;
                st_d.link_idx = lnk_dst;
                st_d.link_val = st_q.pc + LINK_STEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc       <= START_PC;
            st_q.flag     <= 1'b0;
            st_q.taken    <= 1'b0;
            st_q.link_we  <= 1'b0;
            st_q.link_idx <= '0;
            st_q.link_val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o     = st_q.flag;
    assign pc_o       = st_q.pc;
    assign taken_o    = st_q.taken;
    assign link_we_o  = st_q.link_we;
    assign link_idx_o = st_q.link_idx;
    assign link_val_o = st_q.link_val;
endmodule

// File: rtl/cmpbr_checker.sv
module cmpbr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [4:0]  op_code,
    input logic [31:0] op_a,
    input logic [31:0] tgt,
    input logic [4:0]  lnk_dst,
    input logic        flag_o,
    input logic [31:0] pc_o,
    input logic        taken_o,
    input logic        link_we_o,
    input logic [4:0]  link_idx_o,
    input logic [31:0] link_val_o
);
    logic non_cmp;
    assign non_cmp = (op_code == 5'd0) || (op_code > 5'd10);

    assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && non_cmp) |=> (flag_o == $past(flag_o)));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(pc_o) && $stable(flag_o) && !taken_o && !link_we_o));

    assert_branch_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd12 && flag_o) |=> (taken_o && pc_o == $past(tgt)));

    assert_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd11 && flag_o) |=> (!taken_o && pc_o == $past(pc_o) + 32'd4));

    assert_jump_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd14) |=> (taken_o && !link_we_o && pc_o == $past(op_a)));

    assert_link_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd15 && lnk_dst != 5'd0) |=>
            (link_we_o && link_val_o == $past(pc_o) + 32'd8));

    assert_no_zero_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_idx_o != 5'd0));

    assert_taken_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> $past(op_valid));
endmodule

bind cmpbr_unit cmpbr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_a       (op_a),
    .tgt        (tgt),
    .lnk_dst    (lnk_dst),
    .flag_o     (flag_o),
    .pc_o       (pc_o),
    .taken_o    (taken_o),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o),
    .link_val_o (link_val_o)
);

// File: tb/tb_cmpbr_unit.sv
`timescale 1ns/1ps
module tb_cmpbr_unit;
    localparam logic [31:0] START = 32'h0000_1000;

    typedef struct packed {
        logic [4:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] t;
        logic [4:0]  ld;
        logic        eflag;
        logic        etaken;
        logic        elink;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{5'd1,  32'd5,          32'd5,          32'h0,    5'd0, 1'b1, 1'b0, 1'b0}, // R2 eq
        '{5'd12, 32'd0,          32'd0,          32'h2000, 5'd0, 1'b1, 1'b1, 1'b0}, // R4 set taken
        '{5'd2,  32'd7,          32'd7,          32'h0,    5'd0, 1'b0, 1'b0, 1'b0}, // R2 ne
        '{5'd12, 32'd0,          32'd0,          32'h3000, 5'd0, 1'b0, 1'b0, 1'b0}, // R5 not taken
        '{5'd11, 32'd0,          32'd0,          32'h3000, 5'd0, 1'b0, 1'b1, 1'b0}, // R4 clear taken
        '{5'd3,  32'd1,          32'hFFFF_FFFF,  32'h0,    5'd0, 1'b1, 1'b0, 1'b0}, // R2 gts
        '{5'd7,  32'd1,          32'hFFFF_FFFF,  32'h0,    5'd0, 1'b0, 1'b0, 1'b0}, // R2 gtu
        '{5'd5,  32'h8000_0000,  32'd0,          32'h0,    5'd0, 1'b1, 1'b0, 1'b0}, // R2 lts
        '{5'd9,  32'h8000_0000,  32'd0,          32'h0,    5'd0, 1'b0, 1'b0, 1'b0}, // R2 ltu
        '{5'd4,  32'd5,          32'd5,          32'h0,    5'd0, 1'b1, 1'b0, 1'b0}, // R2 ges
        '{5'd8,  32'd4,          32'd5,          32'h0,    5'd0, 1'b0, 1'b0, 1'b0}, // R2 geu
        '{5'd6,  32'hFFFF_FFFE,  32'hFFFF_FFFF,  32'h0,    5'd0, 1'b1, 1'b0, 1'b0}, // R2 les
        '{5'd10, 32'd6,          32'd6,          32'h0,    5'd0, 1'b1, 1'b0, 1'b0}, // R2 leu
        '{5'd13, 32'd0,          32'd0,          32'h4000, 5'd0, 1'b1, 1'b1, 1'b0}, // R6 jmp
        '{5'd11, 32'd0,          32'd0,          32'h5000, 5'd0, 1'b1, 1'b0, 1'b0}, // R5 clear not taken
        '{5'd14, 32'h6000,       32'd0,          32'h0,    5'd0, 1'b1, 1'b1, 1'b0}, // R6 jreg
        '{5'd0,  32'd0,          32'd0,          32'h0,    5'd0, 1'b1, 1'b0, 1'b0}, // R5 nop, R9 pulse ends
        '{5'd15, 32'd0,          32'd0,          32'h7000, 5'd9, 1'b1, 1'b1, 1'b1}, // R7 jal
        '{5'd16, 32'h8000,       32'd0,          32'h0,    5'd0, 1'b1, 1'b1, 1'b0}, // R8 jalr to r0
        '{5'd31, 32'd1,          32'd2,          32'h9000, 5'd3, 1'b1, 1'b0, 1'b0}  // R5 unused code
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [4:0]  op_code;
    logic [31:0] op_a, op_b, tgt;
    logic [4:0]  lnk_dst;
    logic        flag_o, taken_o, link_we_o;
    logic [31:0] pc_o, link_val_o;
    logic [4:0]  link_idx_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmpbr_unit #(.START_PC(START)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_a(op_a), .op_b(op_b), .tgt(tgt), .lnk_dst(lnk_dst),
        .flag_o(flag_o), .pc_o(pc_o), .taken_o(taken_o),
        .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_val_o(link_val_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " R1 flag"}, 32'(flag_o), 32'd0);
        chk({tag, " R1 pc"}, pc_o, START);
        chk({tag, " R1 taken"}, 32'(taken_o), 32'd0);
        chk({tag, " R1 link_we"}, 32'(link_we_o), 32'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pc_m;
        logic [31:0] frozen_pc;
        logic        frozen_flag;
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0;
        op_a = '0; op_b = '0; tgt = '0; lnk_dst = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("start");

        // vector table
        pc_m = START;
        for (int i = 0; i < NV; i++) begin
            op_valid = 1'b1;
            op_code  = VEC[i].op;
            op_a     = VEC[i].a;
            op_b     = VEC[i].b;
            tgt      = VEC[i].t;
            lnk_dst  = VEC[i].ld;
            @(negedge clk);
            chk($sformatf("R2/R3 flag vec %0d", i), 32'(flag_o), 32'(VEC[i].eflag));
            chk($sformatf("R9 taken vec %0d", i), 32'(taken_o), 32'(VEC[i].etaken));
            chk($sformatf("R7/R8 link_we vec %0d", i), 32'(link_we_o), 32'(VEC[i].elink));
            if (VEC[i].elink) begin
                chk($sformatf("R7 link_idx vec %0d", i), 32'(link_idx_o), 32'(VEC[i].ld));
                chk($sformatf("R7 link_val vec %0d", i), link_val_o, pc_m + 32'd8);
            end
            if (VEC[i].etaken)
                pc_m = (VEC[i].op == 5'd14 || VEC[i].op == 5'd16) ? VEC[i].a : VEC[i].t;
            else
                pc_m = pc_m + 32'd4;
            chk($sformatf("R4/R5/R6 pc vec %0d", i), pc_o, pc_m);
        end

        // R10: idle cycles with a compare and a jump on the inputs change nothing
        frozen_pc = pc_o;
        frozen_flag = flag_o;
        op_valid = 1'b0;
        op_code = 5'd2; op_a = 32'd1; op_b = 32'd1;
        @(negedge clk);
        op_code = 5'd15; tgt = 32'hA000; lnk_dst = 5'd4;
        @(negedge clk);
        chk("R10 pc held", pc_o, frozen_pc);
        chk("R10 flag held", 32'(flag_o), 32'(frozen_flag));
        chk("R10 taken low", 32'(taken_o), 32'd0);
        chk("R10 link_we low", 32'(link_we_o), 32'd0);

        // R3: a taken branch-if-set keeps flag at 1
        op_valid = 1'b1; op_code = 5'd12; tgt = 32'hB000;
        @(negedge clk);
        chk("R3 flag after branch", 32'(flag_o), 32'd1);
        chk("R4 branch set pc", pc_o, 32'hB000);
        op_valid = 1'b0;
        @(negedge clk);
        chk("R9 pulse one cycle", 32'(taken_o), 32'd0);

        // reset in the middle of a run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("mid");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule